// File: doc/BRIEF.md
# Multi-mode 24-bit timer/counter

This block is a memory-mapped timer built around one 24-bit up-counter. A two-bit mode field in the control byte selects what the counter does. In interval mode it runs up to compare A and then either returns to zero or holds there. In pulse mode it toggles an output flip-flop at compare A and again at compare B, and compare B also restarts the count. In watchdog mode it counts up to compare A, raises an event and restarts, and it keeps counting even with the count enable off unless a separate disable bit is set. The fourth mode stops the counter.

The counter advances on a count strobe. The strobe is either an external single-cycle enable or an internal one. The internal enable can pass through a power-of-two divider. Each event sets a sticky bit in a status register. A registered level interrupt is the OR of the status bits whose enables are set. Software reaches all registers through a 32-bit bus with byte enables. Reads are combinational and writes take effect at the clock edge.

The mode field works as the state of the block. Its states are IVAL (interval), PULSE, WDOG and OFF. Each transition between them is a control write that selects another mode, and the counter keeps its value across such a write.

Top module: `tmr24_top`

## Requirements
- R1: After reset, compare A (offset 0x08) and compare B (0x0C) read 0x00FFFFFF. Control (0x00), status (0x04), interval (0x10), divider (0x20), pulse (0x30), watchdog (0x40) and the counter (0xF0) read 0, and so do irq and ff_out. Any other offset reads 0.
- R2: The control byte has these fields: bit 7 count enable, bit 6 divider enable, bit 5 counter-clear enable, bit 2 clock select (1 = external), bits 1:0 mode (0 IVAL, 1 PULSE, 2 WDOG, 3 OFF). Bit 4 always reads 0. A control write with bit 7 = 0 and bit 5 = 1 sets the counter to 0 at that edge.
- R3: With clock select = 1, each ext_tick strobe is one count. With clock select = 0 and the divider off, each int_tick strobe is one count. With the divider on, one count takes 2^(1+D) int_tick strobes, where D is bits 2:0 of the divider register.
- R4: The counter changes only on a count strobe or on a control clear. In OFF mode it never advances. In IVAL and PULSE modes it advances only while count enable is 1.
- R5: IVAL mode advances only while the counter differs from compare A. When the counter reaches compare A, status bit 0 sets. If bit 0 of the interval register is 1 the counter returns to 0. Otherwise it holds at compare A, and a held counter sets no status again.
- R6: In PULSE mode, when the next count equals compare A, ff_out toggles, status bit 1 sets and the counter takes that value. Failing that, when the next count equals compare B, ff_out toggles, status bit 2 sets and the counter returns to 0.
- R7: WDOG mode advances unless count enable is 0 and bit 7 of the watchdog register is 1. When the next count equals compare A, status bit 3 sets and the counter returns to 0.
- R8: Compare registers take byte lanes 0 to 2 into bits 23:0, each lane gated by its byte enable. Lane 3 is ignored and bits 31:24 read 0.
- R9: A write to offset 0x04 with byte enable 0 set clears all status bits at that edge. A status set in the same cycle wins over the clear.
- R10: irq updates at the same edge as the status register. It is high when any status bit is set together with its enable. Status bit 0 pairs with interval register bit 15, bit 1 with pulse register bit 14, bit 2 with pulse register bit 15, and bit 3 with watchdog register bit 15.
- R11: ff_out resets to 0, which is the reset value of pulse register bit 0. It changes only at the PULSE trip points of R6 and holds its value in the other modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| int_tick | input | 1 | Internal count enable strobe |
| ext_tick | input | 1 | External count enable strobe |
| irq | output | 1 | Registered level interrupt |
| ff_out | output | 1 | Pulse-mode flip-flop output |

## Verification
Two pairs of events can collide. A count strobe can move the counter onto compare A at the same edge that software clears the status register. A control write can clear the counter while a count is pending. The bench provokes the first pair by driving int_tick and the status write in the same cycle with the counter one step short of compare A. It then expects status bit 0 set, irq high and the counter back at zero. The clear-versus-count pair is judged by reading the counter after each control clear, and the bound checker confirms that the counter never moves without a strobe or a clear.

// File: rtl/tmr24_pkg.sv
package tmr24_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        MODE_IVAL  = 2'd0,
        MODE_PULSE = 2'd1,
        MODE_WDOG  = 2'd2,
        MODE_OFF   = 2'd3
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CMPA  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CMPB  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_IVAL  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DIV   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_PULSE = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_WDOG  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 8'hF0;

    localparam logic [7:0] CTRL_WMASK = 8'hEF;

endpackage

// File: rtl/tmr24_prescale.sv
module tmr24_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_tick,
    input  logic             ext_tick,
    input  logic             ext_sel,
    input  logic             div_en,
    input  logic [DIV_W-1:0] div_sel,
    output logic             cnt_tick
);
    localparam int PRE_W = 1 << DIV_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W:0]   last;
    logic             use_div;
    logic             wrap;

    // span = 2^(1+div_sel) internal strobes per count
    always_comb begin
        span    = (PRE_W+1)'(2) << div_sel;
        last    = span - 1'b1;
        use_div = !ext_sel && div_en;
        wrap    = (pre_q == last[PRE_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pre_q <= '0;
        else if (!use_div)   pre_q <= '0;
        else if (int_tick)   pre_q <= wrap ? '0 : pre_q + 1'b1;
    end

    always_comb begin
        if (ext_sel)      cnt_tick = ext_tick;
        else if (div_en)  cnt_tick = int_tick && wrap;
        else              cnt_tick = int_tick;
    end
endmodule

// File: rtl/tmr24_core.sv
module tmr24_core
    import tmr24_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  tmr_mode_e        mode,
    input  logic             cen,
    input  logic             wdis,
    input  logic             zclr,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             cnt_clr,
    input  logic             st_clr,
    input  logic [3:0]       irq_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [3:0]       st_q,
    output logic             ff_q,
    output logic             irq_q
);
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cnt_d;
    logic [3:0]       st_set;
    logic [3:0]       st_d;
    logic             flip;

    // next-state logic: trip rules per mode
    always_comb begin
        nxt    = cnt_q + 1'b1;
        cnt_d  = cnt_q;
        st_set = '0;
        flip   = 1'b0;
        if (cnt_tick) begin
            unique case (mode)
                MODE_IVAL: begin
                    if (cen && cnt_q != cmp_a) begin
                        if (nxt == cmp_a) begin
                            st_set[0] = 1'b1;
                            cnt_d     = zclr ? '0 : nxt;
                        end else begin
                            cnt_d = nxt;
                        end
                    end
                end
                MODE_PULSE: begin
                    if (cen) begin
                        if (nxt == cmp_a) begin
                            flip      = 1'b1;
                            st_set[1] = 1'b1;
                            cnt_d     = nxt;
                        end else if (nxt == cmp_b) begin
                            flip      = 1'b1;
                            st_set[2] = 1'b1;
                            cnt_d     = '0;
                        end else begin
                            cnt_d = nxt;
                        end
                    end
                end
                MODE_WDOG: begin
                    if (cen || !wdis) begin
                        if (nxt == cmp_a) begin
                            st_set[3] = 1'b1;
                            cnt_d     = '0;
                        end else begin
                            cnt_d = nxt;
                        end
                    end
                end
                MODE_OFF: begin
                    cnt_d = cnt_q;
                end
            endcase
        end
        st_d = (st_clr ? 4'd0 : st_q) | st_set;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            st_q  <= '0;
        end else begin
            cnt_q <= cnt_clr ? '0 : cnt_d;
            st_q  <= st_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            ff_q  <= ff_q ^ flip;
            irq_q <= |(st_d & irq_en);
        end
    end
endmodule

// File: rtl/tmr24_top.sv
module tmr24_top
    import tmr24_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int DIV_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        int_tick,
    input  logic        ext_tick,
    output logic        irq,
    output logic        ff_out
);
    localparam int NLANE = CNT_W / 8;

    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] cmp_a_q, cmp_b_q, cmp_a_d, cmp_b_d;
    logic             iv_ie, iv_zc;
    logic [DIV_W-1:0] div_q;
    logic             pa_ie, pb_ie, ffi_q;
    logic             wd_ie, wd_dis, wd_spare;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       st_q;
    logic             cnt_tick, cnt_clr, st_clr, wen;
    tmr_mode_e        mode;

    assign wen     = bus_sel && bus_wr;
    assign mode    = tmr_mode_e'(ctrl_q[1:0]);
    assign cnt_clr = wen && bus_addr == OFF_CTRL && bus_be[0]
                     && !bus_wdata[7] && bus_wdata[5];
    assign st_clr  = wen && bus_addr == OFF_STAT && bus_be[0];

    always_comb begin
        cmp_a_d = cmp_a_q;
        cmp_b_d = cmp_b_q;
        for (int l = 0; l < NLANE; l++) begin
            if (bus_be[l]) begin
                cmp_a_d[l*8 +: 8] = bus_wdata[l*8 +: 8];
                cmp_b_d[l*8 +: 8] = bus_wdata[l*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cmp_a_q  <= '1;
            cmp_b_q  <= '1;
            iv_ie    <= 1'b0;
            iv_zc    <= 1'b0;
            div_q    <= '0;
            pa_ie    <= 1'b0;
            pb_ie    <= 1'b0;
            ffi_q    <= 1'b0;
            wd_ie    <= 1'b0;
            wd_dis   <= 1'b0;
            wd_spare <= 1'b0;
        end else if (wen) begin
            unique case (bus_addr)
                OFF_CTRL: if (bus_be[0]) ctrl_q <= bus_wdata[7:0] & CTRL_WMASK;
                OFF_CMPA: cmp_a_q <= cmp_a_d;
                OFF_CMPB: cmp_b_q <= cmp_b_d;
                OFF_IVAL: begin
                    if (bus_be[1]) iv_ie <= bus_wdata[15];
                    if (bus_be[0]) iv_zc <= bus_wdata[0];
                end
                OFF_DIV:  if (bus_be[0]) div_q <= bus_wdata[DIV_W-1:0];
                OFF_PULSE: begin
                    if (bus_be[1]) begin
                        pb_ie <= bus_wdata[15];
                        pa_ie <= bus_wdata[14];
                    end
                    if (bus_be[0]) ffi_q <= bus_wdata[0];
                end
                OFF_WDOG: begin
                    if (bus_be[1]) wd_ie <= bus_wdata[15];
                    if (bus_be[0]) begin
                        wd_dis   <= bus_wdata[7];
                        wd_spare <= bus_wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFF_CTRL:  bus_rdata = {24'd0, ctrl_q};
            OFF_STAT:  bus_rdata = {28'd0, st_q};
            OFF_CMPA:  bus_rdata = 32'(cmp_a_q);
            OFF_CMPB:  bus_rdata = 32'(cmp_b_q);
            OFF_IVAL:  bus_rdata = {16'd0, iv_ie, 14'd0, iv_zc};
            OFF_DIV:   bus_rdata = 32'(div_q);
            OFF_PULSE: bus_rdata = {16'd0, pb_ie, pa_ie, 13'd0, ffi_q};
            OFF_WDOG:  bus_rdata = {16'd0, wd_ie, 7'd0, wd_dis, 6'd0, wd_spare};
            OFF_COUNT: bus_rdata = 32'(cnt_q);
            default:   bus_rdata = 32'd0;
        endcase
    end

    tmr24_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_tick (int_tick),
        .ext_tick (ext_tick),
        .ext_sel  (ctrl_q[2]),
        .div_en   (ctrl_q[6]),
        .div_sel  (div_q),
        .cnt_tick (cnt_tick)
    );

    tmr24_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_tick (cnt_tick),
        .mode     (mode),
        .cen      (ctrl_q[7]),
        .wdis     (wd_dis),
        .zclr     (iv_zc),
        .cmp_a    (cmp_a_q),
        .cmp_b    (cmp_b_q),
        .cnt_clr  (cnt_clr),
        .st_clr   (st_clr),
        .irq_en   ({wd_ie, pb_ie, pa_ie, iv_ie}),
        .cnt_q    (cnt_q),
        .st_q     (st_q),
        .ff_q     (ff_out),
        .irq_q    (irq)
    );
endmodule

// File: rtl/tmr24_checker.sv
module tmr24_checker
    import tmr24_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input tmr_mode_e        mode,
    input logic             cen,
    input logic             wdis,
    input logic             cnt_tick,
    input logic             cnt_clr,
    input logic             st_clr,
    input logic [CNT_W-1:0] cnt,
    input logic [3:0]       st,
    input logic             irq,
    input logic             ff
);
    // R4: no strobe and no clear leaves the counter alone
    a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !cnt_clr) |=> $stable(cnt));

    // R4: OFF mode never advances
    a_r4_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !cnt_clr) |=> $stable(cnt));

    // R7: watchdog stopped by enable off plus disable bit
    a_r7_wdog_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WDOG && !cen && wdis && !cnt_clr) |=> $stable(cnt));

    // R9: a clear with no strobe empties the status register
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (st_clr && !cnt_tick) |=> (st == 4'd0));

    // R10: no status means no interrupt
    a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 4'd0) |-> !irq);

    // R11: the flip-flop moves only in pulse mode
    a_r11_ff_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_PULSE) |=> $stable(ff));
endmodule

bind tmr24_top tmr24_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cen      (ctrl_q[7]),
    .wdis     (wd_dis),
    .cnt_tick (cnt_tick),
    .cnt_clr  (cnt_clr),
    .st_clr   (st_clr),
    .cnt      (cnt_q),
    .st       (st_q),
    .irq      (irq),
    .ff       (ff_out)
);

// File: tb/test_tmr24_top.sv
module test_tmr24_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        int_tick = 1'b0, ext_tick = 1'b0;
    logic        irq, ff_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 ff_out
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    tmr24_top i_tmr24_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int_tick(int_tick), .ext_tick(ext_tick),
        .irq(irq), .ff_out(ff_out)
    );

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'd0, irq};
                default: act = {31'd0, ff_out};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic tick_int(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 int_tick = 1;
            @(posedge clk); #1 int_tick = 0;
        end
    endtask

    task automatic tick_ext(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 ext_tick = 1;
            @(posedge clk); #1 ext_tick = 0;
        end
    endtask

    // count strobe and status clear at the same edge
    task automatic tick_and_clear();
        @(posedge clk); #1;
        int_tick = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_be = 4'h1; bus_wdata = 0;
        @(posedge clk); #1;
        int_tick = 0; bus_sel = 0; bus_wr = 0;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1 bus_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_pin(input int k, input logic e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        it.kind = k; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset values and unmapped reads
        exp_rd(8'h08, 32'h00FFFFFF, "R1 cmpA reset");
        exp_rd(8'h0C, 32'h00FFFFFF, "R1 cmpB reset");
        exp_rd(8'h00, 32'h0, "R1 ctrl reset");
        exp_rd(8'hF0, 32'h0, "R1 count reset");
        exp_rd(8'h14, 32'h0, "R1 unmapped");
        exp_pin(1, 1'b0, "R1 irq reset");
        exp_pin(2, 1'b0, "R11 ff reset");

        // R2 bit 4 not writable
        wr(8'h00, 4'h1, 32'hFF);
        exp_rd(8'h00, 32'hEF, "R2 ctrl mask");
        wr(8'h00, 4'h1, 32'h00);

        // R8 compare lanes
        wr(8'h08, 4'hF, 32'hAB000005);
        exp_rd(8'h08, 32'h5, "R8 lane3 ignored");
        wr(8'h08, 4'h2, 32'h00000200);
        exp_rd(8'h08, 32'h205, "R8 single lane");
        wr(8'h08, 4'hF, 32'h5);

        // R5 interval, hold at A
        wr(8'h10, 4'h3, 32'h8000);
        wr(8'h00, 4'h1, 32'h80);
        tick_int(3);
        exp_rd(8'hF0, 32'd3, "R3 int count");
        exp_rd(8'h04, 32'd0, "R5 no status yet");
        tick_int(2);
        exp_rd(8'hF0, 32'd5, "R5 reach A");
        exp_rd(8'h04, 32'd1, "R5 status bit0");
        exp_pin(1, 1'b1, "R10 irq interval");
        tick_int(2);
        exp_rd(8'hF0, 32'd5, "R5 hold at A");

        // R9 clear, then held counter sets nothing again
        wr(8'h04, 4'h1, 32'h0);
        exp_rd(8'h04, 32'd0, "R9 status cleared");
        exp_pin(1, 1'b0, "R10 irq cleared");
        tick_int(2);
        exp_rd(8'h04, 32'd0, "R5 no re-set while held");
        exp_pin(1, 1'b0, "R5 no irq while held");

        // R2 control clear, R5 zero-clear, R9 set beats clear
        wr(8'h10, 4'h3, 32'h8001);
        wr(8'h00, 4'h1, 32'h20);
        exp_rd(8'hF0, 32'd0, "R2 counter clear");
        wr(8'h00, 4'h1, 32'h80);
        tick_int(4);
        exp_rd(8'hF0, 32'd4, "R4 counting enabled");
        tick_and_clear();
        exp_rd(8'h04, 32'd1, "R9 set wins over clear");
        exp_pin(1, 1'b1, "R9 irq after collision");
        exp_rd(8'hF0, 32'd0, "R5 zero clear");
        wr(8'h04, 4'h1, 32'h0);

        // R3 divider 2^(1+1)=4
        wr(8'h20, 4'h1, 32'h1);
        wr(8'h00, 4'h1, 32'hC0);
        tick_int(3);
        exp_rd(8'hF0, 32'd0, "R3 divider not yet");
        tick_int(1);
        exp_rd(8'hF0, 32'd1, "R3 divider count");

        // R3 external clock
        wr(8'h00, 4'h1, 32'h84);
        tick_int(2);
        exp_rd(8'hF0, 32'd1, "R3 int ignored on ext");
        tick_ext(1);
        exp_rd(8'hF0, 32'd2, "R3 ext count");

        // R6 pulse mode A=2 B=4
        wr(8'h00, 4'h1, 32'h20);
        wr(8'h08, 4'hF, 32'h2);
        wr(8'h0C, 4'hF, 32'h4);
        wr(8'h30, 4'h3, 32'h4000);
        wr(8'h00, 4'h1, 32'h81);
        tick_int(1);
        exp_pin(2, 1'b0, "R6 ff before A");
        tick_int(1);
        exp_pin(2, 1'b1, "R6 ff at A");
        exp_rd(8'h04, 32'd2, "R6 status bit1");
        exp_pin(1, 1'b1, "R10 irq pulse A");
        tick_int(2);
        exp_pin(2, 1'b0, "R6 ff at B");
        exp_rd(8'h04, 32'd6, "R6 status bit2");
        exp_rd(8'hF0, 32'd0, "R6 clear at B");
        wr(8'h04, 4'h1, 32'h0);
        exp_pin(1, 1'b0, "R9 clear pulse");
        tick_int(2);
        exp_pin(2, 1'b1, "R6 second period");

        // R4 OFF mode, R11 ff holds
        wr(8'h00, 4'h1, 32'h83);
        tick_int(3);
        exp_rd(8'hF0, 32'd2, "R4 off holds");
        exp_pin(2, 1'b1, "R11 ff holds off");

        // R7 watchdog counts while enable off
        wr(8'h04, 4'h1, 32'h0);
        wr(8'h40, 4'h3, 32'h8000);
        wr(8'h00, 4'h1, 32'h22);
        tick_int(1);
        exp_rd(8'hF0, 32'd1, "R7 counts with enable off");
        tick_int(1);
        exp_rd(8'h04, 32'd8, "R7 status bit3");
        exp_rd(8'hF0, 32'd0, "R7 restart");
        exp_pin(1, 1'b1, "R10 irq watchdog");
        exp_pin(2, 1'b1, "R11 ff holds wdog");
        wr(8'h40, 4'h3, 32'h8080);
        exp_rd(8'h40, 32'h8080, "R7 wdog reg");
        tick_int(2);
        exp_rd(8'hF0, 32'd0, "R7 disabled");
        wr(8'h00, 4'h1, 32'h82);
        tick_int(1);
        exp_rd(8'hF0, 32'd1, "R7 enable overrides disable");

        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule